// File: doc/BRIEF.md
# Microcontroller Power Mode Controller

This block decides the clocking state of a small 8-bit microcontroller. Software writes a two-bit mode field. One bit asks for a light sleep, where only the core clock stops. The other asks for a deep sleep, where the core clock, the PLL and the peripheral clocks all stop and the DAC output floats. In deep sleep the oscillator keeps running or halts according to a configuration input. The interval timer, which runs straight from the oscillator, can be kept alive through deep sleep.

The controller also chooses which events end a low-power state. Light sleep ends on any enabled interrupt. Deep sleep ends only on a small set of sources, and each of those has its own enable. After deep sleep the PLL is restarted, and the core clock stays off until the PLL reports lock. On every wake-up through an interrupt, the controller gives the core a one-cycle wake pulse and clears the mode field. A synchronous reset brings the block back to full run from any state. Every output is registered.

Top module: `pmc_top`

## Requirements
- R1: While `rst` is high, and on the clock after it is released, `core_clk_en`, `pll_en`, `osc_en`, `periph_clk_en` and `tmr_clk_en` are 1, `dac_hiz` is 0, `wake_pulse` is 0 and `mode_bits` is 2'b00.
- R2: In run state, a write (`mode_wr`=1) of value 2'b01 takes effect at the next clock edge. It enters idle: `core_clk_en`=0, `pll_en`, `osc_en`, `periph_clk_en` and `tmr_clk_en` stay 1, `dac_hiz`=0, and `mode_bits` reads 2'b01.
- R3: In run state, a write whose bit 1 is set (2'b10 or 2'b11) enters power-down at the next edge, so bit 1 has priority over bit 0. In power-down `core_clk_en`, `pll_en` and `periph_clk_en` are 0, `dac_hiz` is 1, and `mode_bits` holds the written value.
- R4: In power-down, `osc_en` equals the inverse of `osc_off_pd`. `tmr_clk_en` is 1 only when `tmr_pd_en` is 1 and the oscillator runs.
- R5: Idle ends at the edge after any bit of `irq_req & irq_en` is 1. At that edge `core_clk_en` returns to 1, `wake_pulse` is 1 for exactly one cycle and `mode_bits` clears to 2'b00. Requests whose enable bit is 0, and the power-down-only sources, do not end idle.
- R6: Power-down ends only when one of these is true: `spi_irq` with `spi_pd_en`, `tmr_irq` with `tmr_pd_en` while the oscillator runs, or `xint_n` low with `xint_pd_en`. The lines of `irq_req` never end power-down. When power-down ends, the block enters a relock state: `pll_en`, `osc_en`, `periph_clk_en` and `tmr_clk_en` are 1, `dac_hiz` is 0 and `core_clk_en` stays 0.
- R7: A low `xint_n` is ignored during a guard window after power-down entry. The window lasts GUARD_MC*CLKS_PER_MC clocks: the level is first honoured once that many clocks have passed in power-down after the entry edge.
- R8: In relock, `core_clk_en` stays 0 while `pll_lock` is 0. At the edge after `pll_lock` is 1 the block returns to run, with `wake_pulse` high for one cycle and `mode_bits` cleared to 2'b00.
- R9: A mode write is honoured only in run state. In idle, power-down or relock it leaves `mode_bits` and the state unchanged. A write of 2'b00 in run changes nothing.
- R10: Asserting `rst` in idle or power-down restores the R1 state at the next edge without a wake pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr | input | 1 | Write strobe for the mode field |
| mode_wdata | input | 2 | Mode value; bit 0 idle, bit 1 power-down |
| osc_off_pd | input | 1 | Halt the oscillator during power-down |
| tmr_pd_en | input | 1 | Keep the interval timer running in power-down |
| spi_pd_en | input | 1 | Let the serial interrupt end power-down |
| xint_pd_en | input | 1 | Let the external pin end power-down |
| irq_req | input | N_IRQ | Interrupt request lines |
| irq_en | input | N_IRQ | Enable per request line |
| spi_irq | input | 1 | Serial interface interrupt |
| tmr_irq | input | 1 | Interval timer interrupt |
| xint_n | input | 1 | External interrupt pin, active low |
| pll_lock | input | 1 | PLL lock-ready indication |
| core_clk_en | output | 1 | Core clock enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| tmr_clk_en | output | 1 | Interval timer clock enable |
| dac_hiz | output | 1 | DAC output tri-state control |
| wake_pulse | output | 1 | One-cycle pulse on resuming after an interrupt |
| mode_bits | output | 2 | Current mode field |

## Verification
The bench builds the block with N_IRQ=5 and CLKS_PER_MC=3, which gives a six-clock guard window. That keeps the masked and honoured phases of the external-pin wake-up within a few cycles of each other. Five request lines are enough to mix enabled and masked requests on different bit positions. The reference model covers every combination of oscillator halt and timer keep-alive, and it holds the lock input low for several cycles so that the relock wait is seen.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_IDLE   = 2'd1,
    PM_DOWN   = 2'd2,
    PM_RELOCK = 2'd3
  } pm_state_t;

  typedef struct packed {
    logic core;
    logic pll;
    logic osc;
    logic periph;
    logic tmr;
    logic dac_hiz;
  } clk_ctl_t;

  // Clock-enable pattern for a given state and the deep-sleep configuration.
  function automatic clk_ctl_t ctl_for(pm_state_t s, logic osc_off, logic tmr_keep);
    clk_ctl_t c;
    c = '{core: 1'b1, pll: 1'b1, osc: 1'b1, periph: 1'b1, tmr: 1'b1, dac_hiz: 1'b0};
    case (s)
      PM_IDLE:   c.core = 1'b0;
      PM_DOWN: begin
        c.core    = 1'b0;
        c.pll     = 1'b0;
        c.periph  = 1'b0;
        c.osc     = ~osc_off;
        c.tmr     = tmr_keep & ~osc_off;
        c.dac_hiz = 1'b1;
      end
      PM_RELOCK: c.core = 1'b0;
      default:   c.core = 1'b1;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int N_IRQ = 4
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             spi_irq,
  input  logic             spi_pd_en,
  input  logic             tmr_irq,
  input  logic             tmr_pd_en,
  input  logic             osc_off_pd,
  input  logic             xint_n,
  input  logic             xint_pd_en,
  input  logic             guard_open,
  output logic             idle_wake,
  output logic             pd_wake
);

  logic [N_IRQ-1:0] hit;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign hit[i] = irq_req[i] & irq_en[i];
  end

  logic spi_src, tmr_src, xint_src;

  always_comb begin
    spi_src   = spi_irq & spi_pd_en;
    tmr_src   = tmr_irq & tmr_pd_en & ~osc_off_pd;
    xint_src  = ~xint_n & xint_pd_en & guard_open;
    idle_wake = |hit;
    pd_wake   = spi_src | tmr_src | xint_src;
  end

endmodule

// File: rtl/pmc_guard.sv
module pmc_guard #(
  parameter int GUARD = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic active,
  output logic open
);

  localparam int W = (GUARD < 1) ? 1 : $clog2(GUARD + 1);
  localparam logic [W-1:0] LOAD = W'(GUARD);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (arm) begin
      cnt_q <= LOAD;
    end else if (active && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open = (cnt_q == '0);

endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       idle_wake,
  input  logic       pd_wake,
  input  logic       pll_lock,
  input  logic       osc_off_pd,
  input  logic       tmr_pd_en,
  output pm_state_t  state,
  output logic [1:0] mode_bits,
  output clk_ctl_t   ctl,
  output logic       wake_pulse,
  output logic       arm_guard
);

  pm_state_t  state_q, state_d;
  logic [1:0] mode_q, mode_d;
  logic       wake_d;

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    wake_d    = 1'b0;
    arm_guard = 1'b0;
    case (state_q)
      PM_RUN: begin
        if (mode_wr) begin
          mode_d = mode_wdata;
          if (mode_wdata[1]) begin
            state_d   = PM_DOWN;
            arm_guard = 1'b1;
          end else if (mode_wdata[0]) begin
            state_d = PM_IDLE;
          end
        end
      end
      PM_IDLE: begin
        if (idle_wake) begin
          state_d = PM_RUN;
          mode_d  = 2'b00;
          wake_d  = 1'b1;
        end
      end
      PM_DOWN: begin
        if (pd_wake) state_d = PM_RELOCK;
      end
      PM_RELOCK: begin
        if (pll_lock) begin
          state_d = PM_RUN;
          mode_d  = 2'b00;
          wake_d  = 1'b1;
        end
      end
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PM_RUN;
      mode_q     <= 2'b00;
      ctl        <= ctl_for(PM_RUN, 1'b0, 1'b0);
      wake_pulse <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      ctl        <= ctl_for(state_d, osc_off_pd, tmr_pd_en);
      wake_pulse <= wake_d;
    end
  end

  assign state     = state_q;
  assign mode_bits = mode_q;

endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int N_IRQ       = 4,
  parameter int GUARD_MC    = 2,
  parameter int CLKS_PER_MC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [1:0]       mode_wdata,
  input  logic             osc_off_pd,
  input  logic             tmr_pd_en,
  input  logic             spi_pd_en,
  input  logic             xint_pd_en,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             spi_irq,
  input  logic             tmr_irq,
  input  logic             xint_n,
  input  logic             pll_lock,
  output logic             core_clk_en,
  output logic             pll_en,
  output logic             osc_en,
  output logic             periph_clk_en,
  output logic             tmr_clk_en,
  output logic             dac_hiz,
  output logic             wake_pulse,
  output logic [1:0]       mode_bits
);

  localparam int GUARD = GUARD_MC * CLKS_PER_MC;

  pm_state_t state;
  clk_ctl_t  ctl;
  logic      idle_wake, pd_wake, guard_open, arm_guard, in_down;

  assign in_down = (state == PM_DOWN);

  pmc_wake #(.N_IRQ(N_IRQ)) u_wake (
    .irq_req    (irq_req),
    .irq_en     (irq_en),
    .spi_irq    (spi_irq),
    .spi_pd_en  (spi_pd_en),
    .tmr_irq    (tmr_irq),
    .tmr_pd_en  (tmr_pd_en),
    .osc_off_pd (osc_off_pd),
    .xint_n     (xint_n),
    .xint_pd_en (xint_pd_en),
    .guard_open (guard_open),
    .idle_wake  (idle_wake),
    .pd_wake    (pd_wake)
  );

  pmc_guard #(.GUARD(GUARD)) u_guard (
    .clk    (clk),
    .rst    (rst),
    .arm    (arm_guard),
    .active (in_down),
    .open   (guard_open)
  );

  pmc_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mode_wr    (mode_wr),
    .mode_wdata (mode_wdata),
    .idle_wake  (idle_wake),
    .pd_wake    (pd_wake),
    .pll_lock   (pll_lock),
    .osc_off_pd (osc_off_pd),
    .tmr_pd_en  (tmr_pd_en),
    .state      (state),
    .mode_bits  (mode_bits),
    .ctl        (ctl),
    .wake_pulse (wake_pulse),
    .arm_guard  (arm_guard)
  );

  assign core_clk_en   = ctl.core;
  assign pll_en        = ctl.pll;
  assign osc_en        = ctl.osc;
  assign periph_clk_en = ctl.periph;
  assign tmr_clk_en    = ctl.tmr;
  assign dac_hiz       = ctl.dac_hiz;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst,
  input logic       core_clk_en,
  input logic       pll_en,
  input logic       osc_en,
  input logic       periph_clk_en,
  input logic       tmr_clk_en,
  input logic       dac_hiz,
  input logic       wake_pulse,
  input logic [1:0] mode_bits
);

  p_pd_gating_r3: assert property (@(posedge clk) disable iff (rst)
    dac_hiz |-> (!core_clk_en && !pll_en && !periph_clk_en));

  p_tmr_needs_osc_r4: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> !tmr_clk_en);

  p_wake_clears_mode_r5: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |-> (core_clk_en && mode_bits == 2'b00));

  p_core_rise_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(core_clk_en)) |-> wake_pulse);

  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> !wake_pulse);

  p_core_needs_pll_r8: assert property (@(posedge clk) disable iff (rst)
    core_clk_en |-> (pll_en && osc_en && periph_clk_en));

  p_mode_held_r9: assert property (@(posedge clk) disable iff (rst)
    (!core_clk_en && !$past(core_clk_en)) |-> $stable(mode_bits));

endmodule

bind pmc_top pmc_checker u_pmc_checker (
  .clk           (clk),
  .rst           (rst),
  .core_clk_en   (core_clk_en),
  .pll_en        (pll_en),
  .osc_en        (osc_en),
  .periph_clk_en (periph_clk_en),
  .tmr_clk_en    (tmr_clk_en),
  .dac_hiz       (dac_hiz),
  .wake_pulse    (wake_pulse),
  .mode_bits     (mode_bits)
);

// File: tb/pmc_top_tb_top.sv
`timescale 1ns/1ps
module pmc_top_tb_top;

  localparam int N_IRQ = 5;
  localparam int GMC   = 2;
  localparam int CPM   = 3;
  localparam int GUARD = GMC * CPM;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic osc_off_pd = 1'b0, tmr_pd_en = 1'b0, spi_pd_en = 1'b0, xint_pd_en = 1'b0;
  logic [N_IRQ-1:0] irq_req = '0, irq_en = '0;
  logic spi_irq = 1'b0, tmr_irq = 1'b0, xint_n = 1'b1, pll_lock = 1'b0;
  logic core_clk_en, pll_en, osc_en, periph_clk_en, tmr_clk_en, dac_hiz, wake_pulse;
  logic [1:0] mode_bits;

  always #10 clk = ~clk;

  pmc_top #(.N_IRQ(N_IRQ), .GUARD_MC(GMC), .CLKS_PER_MC(CPM)) dut_i (
    .clk(clk), .rst(rst), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .osc_off_pd(osc_off_pd), .tmr_pd_en(tmr_pd_en), .spi_pd_en(spi_pd_en),
    .xint_pd_en(xint_pd_en), .irq_req(irq_req), .irq_en(irq_en),
    .spi_irq(spi_irq), .tmr_irq(tmr_irq), .xint_n(xint_n), .pll_lock(pll_lock),
    .core_clk_en(core_clk_en), .pll_en(pll_en), .osc_en(osc_en),
    .periph_clk_en(periph_clk_en), .tmr_clk_en(tmr_clk_en), .dac_hiz(dac_hiz),
    .wake_pulse(wake_pulse), .mode_bits(mode_bits)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;
  string tag = "R1";

  // Reference model: 0 run, 1 light sleep, 2 deep sleep, 3 waiting for lock
  int m_state = 0;
  int m_guard = 0;
  logic [1:0] m_mode = 2'b00;
  logic m_wake = 1'b0;
  logic [5:0] m_clk = 6'b111110;

  function automatic logic [5:0] exp_clk(int s, logic off, logic keep);
    case (s)
      1: return 6'b011110;
      2: return {3'b000, ~off, 1'b0, 1'b1} | {4'b0000, keep & ~off, 1'b0} & 6'b000010
                | {2'b00, 1'b0, 1'b0, 1'b0, 1'b0};
      3: return 6'b011110;
      default: return 6'b111110;
    endcase
  endfunction

  // Bit order {core, pll, osc, periph, tmr, dac_hiz}
  function automatic logic [5:0] down_clk(logic off, logic keep);
    logic [5:0] v;
    v = 6'b000001;
    v[3] = ~off;
    v[1] = keep & ~off;
    return v;
  endfunction

  always @(posedge clk) begin
    int ns;
    logic wk;
    if (rst) begin
      m_state = 0; m_mode = 2'b00; m_guard = 0; m_wake = 1'b0; m_clk = 6'b111110;
    end else begin
      ns = m_state;
      wk = 1'b0;
      case (m_state)
        0: if (mode_wr) begin
             m_mode = mode_wdata;
             if (mode_wdata[1]) begin ns = 2; m_guard = GUARD; end
             else if (mode_wdata[0]) ns = 1;
           end
        1: if ((irq_req & irq_en) != 0) begin ns = 0; wk = 1'b1; m_mode = 2'b00; end
        2: begin
             if ((spi_irq && spi_pd_en) || (tmr_irq && tmr_pd_en && !osc_off_pd) ||
                 (!xint_n && xint_pd_en && m_guard == 0)) ns = 3;
             if (m_guard > 0) m_guard = m_guard - 1;
           end
        default: if (pll_lock) begin ns = 0; wk = 1'b1; m_mode = 2'b00; end
      endcase
      m_state = ns;
      m_wake  = wk;
      m_clk   = (ns == 2) ? down_clk(osc_off_pd, tmr_pd_en) : exp_clk(ns, osc_off_pd, tmr_pd_en);
    end
  end

  // Compare every clock, after outputs and model have settled
  always @(posedge clk) begin
    logic [8:0] act, exp;
    #2;
    cycles++;
    if (!done) begin
      act = {core_clk_en, pll_en, osc_en, periph_clk_en, tmr_clk_en, dac_hiz, wake_pulse, mode_bits};
      exp = {m_clk, m_wake, m_mode};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s cycle %0d: actual %b expected %b", tag, cycles, act, exp);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] v);
    @(negedge clk);
    mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk);
    mode_wr = 1'b0; mode_wdata = 2'b00;
  endtask

  // Direct check at the ports, sampled away from the clock edge
  task automatic expect_core(string t, logic v);
    checks++;
    if (core_clk_en !== v) begin
      errors++;
      $display("FAIL %s: core_clk_en actual %b expected %b", t, core_clk_en, v);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    tick(3);
    @(negedge clk); rst = 1'b0;
    tick(2);
    expect_core("R1", 1'b1);

    tag = "R9";                       // write of 00 in run is a no-op
    wr(2'b00); tick(2);

    tag = "R2";
    wr(2'b01); tick(2);
    expect_core("R2", 1'b0);

    tag = "R5";                       // masked and deep-sleep-only sources keep idle
    irq_req = 5'b10100; irq_en = 5'b01011; spi_irq = 1'b1; spi_pd_en = 1'b1; tmr_irq = 1'b1;
    tick(3);
    tag = "R9";
    wr(2'b10); tick(1);
    expect_core("R9", 1'b0);
    tag = "R5";
    irq_en = 5'b00100;
    tick(1);
    irq_req = '0; irq_en = '0; spi_irq = 1'b0; spi_pd_en = 1'b0; tmr_irq = 1'b0;
    tick(2);
    expect_core("R5", 1'b1);

    tag = "R3";                       // both bits: power-down wins
    osc_off_pd = 1'b0; tmr_pd_en = 1'b1;
    wr(2'b11); tick(2);
    tag = "R6";
    irq_req = 5'b11111; irq_en = 5'b11111; spi_irq = 1'b1;
    tick(4);
    tag = "R9";
    wr(2'b01); tick(1);
    tag = "R6";
    spi_pd_en = 1'b1;
    tick(1);
    spi_irq = 1'b0; spi_pd_en = 1'b0; irq_req = '0; irq_en = '0;
    tag = "R8";
    tick(4);
    expect_core("R8", 1'b0);
    pll_lock = 1'b1; tick(1); pll_lock = 1'b0;
    tick(2);
    expect_core("R8", 1'b1);

    tag = "R4";                       // halted oscillator: timer off and cannot wake
    osc_off_pd = 1'b1; tmr_pd_en = 1'b1;
    xint_pd_en = 1'b1;
    @(negedge clk); mode_wr = 1'b1; mode_wdata = 2'b10; xint_n = 1'b0; tmr_irq = 1'b1;
    @(negedge clk); mode_wr = 1'b0; mode_wdata = 2'b00;
    tag = "R7";                       // pin held low from entry, honoured after guard
    tick(GUARD - 1);
    expect_core("R7", 1'b0);
    tick(4);
    xint_n = 1'b1; tmr_irq = 1'b0; xint_pd_en = 1'b0;
    pll_lock = 1'b1; tick(2); pll_lock = 1'b0;
    tick(1);
    expect_core("R7", 1'b1);

    tag = "R4";                       // oscillator kept, timer wakes
    osc_off_pd = 1'b0; tmr_pd_en = 1'b1;
    wr(2'b10); tick(3);
    tmr_irq = 1'b1; pll_lock = 1'b1;
    tick(1); tmr_irq = 1'b0;
    tick(3); pll_lock = 1'b0;
    tmr_pd_en = 1'b0; osc_off_pd = 1'b1;
    wr(2'b10); tick(3);
    osc_off_pd = 1'b0; tmr_pd_en = 1'b1; tick(2);

    tag = "R10";                      // reset out of power-down, then out of idle
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    tick(1);
    expect_core("R10", 1'b1);
    wr(2'b01); tick(2);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    tick(2);
    expect_core("R10", 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule